// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces periodic interrupt ticks for a real-time clock. It watches a free-running 15-bit prescaler that advances once per cycle of a 32768 Hz time base. It emits a tick each time that count lands on a multiple of the selected period. The time base reaches the block as a one-cycle step strobe in the system clock domain. A 4-bit rate code selects a period that is a power of two. A 3-bit divider control field decides whether the prescaler runs, freezes or is held in reset. A separate enable bit arms periodic interrupts.

Each tick is a one-cycle pulse that appears on two outputs at once. One output sets the periodic flag and the other requests the interrupt line. The flag storage and the interrupt line logic sit outside this block.

The tick sequencer is a three-state machine:
- IDLE: generation is off.
- ARMED: generation is on and the block is waiting for a boundary.
- FIRE: the pulse cycle.

Its transitions are:
- IDLE→ARMED when enabled.
- IDLE→FIRE and ARMED→FIRE when enabled and a boundary step occurs.
- ARMED→IDLE and FIRE→IDLE when disabled.
- FIRE→ARMED when still enabled and no boundary occurs.
- FIRE→FIRE when a boundary occurs, which cannot happen on two consecutive steps.

Top module: `periodic_rate_gen`

## Requirements
- R1: While reset is asserted both outputs are low. Reset clears the prescaler to zero, so with rate code 3 the first tick follows the fourth step after reset.
- R2: For rate codes 3 to 15 the tick period is 2^(code-1) steps: code 3 gives 4 steps and code 15 gives 16384 steps.
- R3: Rate code 1 gives the same 128-step period as code 8. Rate code 2 gives the same 256-step period as code 9.
- R4: Rate code 0 produces no ticks at all.
- R5: With the enable input low, no ticks are produced for any rate code.
- R6: A tick occurs only when the prescaler count reaches a multiple of the period. Enabling generation part-way through a period yields the first tick at the next such multiple, not a full period later.
- R7: Divider control values 3'b110 and 3'b111 hold the prescaler at zero and suppress ticks. After release, a full period of steps is needed before the next tick.
- R8: Divider control values 3'b011, 3'b100 and 3'b101 freeze the prescaler, and steps are ignored. Counting resumes from the frozen value once the field returns to 3'b010 or below.
- R9: A change of rate code emits no tick by itself. The next tick comes at the next boundary of the new period.
- R10: A tick is high for exactly one system clock cycle. It is the cycle after the step strobe that brings the count onto a boundary, and both outputs are asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_step_i | input | 1 | One-cycle strobe per 32768 Hz time-base cycle |
| rate_code_i | input | 4 | Rate select; 0 disables generation |
| div_ctrl_i | input | 3 | Divider control: 0..2 run, 3..5 freeze, 6..7 hold in reset |
| pie_en_i | input | 1 | Periodic interrupt enable |
| pf_set_o | output | 1 | One-cycle pulse that sets the periodic flag |
| irq_req_o | output | 1 | One-cycle pulse requesting the interrupt line |

## Verification
Several patterns are run from reset and their tick totals are compared with hand-derived counts:
- Back-to-back strobes at the shortest and longest periods separate a correct exponent from an off-by-one shift.
- Codes 1 and 2 run beside codes 8 and 9 to show the aliasing.
- Sparse strobes, spaced three cycles apart, show that the pulse width depends on the system clock and not on the step rate.
- Enabling or changing the code mid-period tells phase-aligned ticks apart from ticks that restart their count.
- Divider hold runs distinguish a prescaler cleared to zero from one merely frozen.

A cycle-accurate model of the prescaler in the bench predicts the output in every cycle.

// File: rtl/prg_pkg.sv
package prg_pkg;

    localparam int CODE_W = 4;
    localparam int CNT_W  = 15;
    localparam int DIV_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } prg_state_e;

    // Codes 1 and 2 alias onto 8 and 9.
    function automatic logic [CODE_W-1:0] eff_code(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] r;
        if (c == CODE_W'(1))      r = CODE_W'(8);
        else if (c == CODE_W'(2)) r = CODE_W'(9);
        else                      r = c;
        return r;
    endfunction

endpackage

// File: rtl/prg_prescaler.sv
module prg_prescaler #(
    parameter int CNT_W = prg_pkg::CNT_W,
    parameter int DIV_W = prg_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [DIV_W-1:0] div_ctrl_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             adv_o,
    output logic             div_reset_o
);
    localparam logic [DIV_W-1:0] RUN_MAX = DIV_W'(2);

    logic [CNT_W-1:0] cnt_q;
    logic             counting;

    assign div_reset_o = (div_ctrl_i[DIV_W-1:DIV_W-2] == 2'b11);
    assign counting    = (div_ctrl_i <= RUN_MAX);
    assign adv_o       = step_i && counting;
    assign cnt_next_o  = cnt_q + CNT_W'(1);
    assign cnt_o       = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (div_reset_o) cnt_q <= '0;
        else if (adv_o)       cnt_q <= cnt_next_o;
    end

    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ctrl_i[DIV_W-1:DIV_W-2] == 2'b11) |=> (cnt_q == '0));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((div_ctrl_i[DIV_W-1:DIV_W-2] != 2'b11) && (!step_i || div_ctrl_i > RUN_MAX))
        |=> $stable(cnt_q));

endmodule

// File: rtl/prg_rate_decode.sv
module prg_rate_decode #(
    parameter int CODE_W = prg_pkg::CODE_W,
    parameter int CNT_W  = prg_pkg::CNT_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              code_nz_o,
    output logic [CNT_W-1:0]  mask_o
);
    logic [CODE_W-1:0] eff;
    logic [CODE_W-1:0] shift;

    assign code_nz_o = (code_i != '0);
    assign eff       = prg_pkg::eff_code(code_i);
    assign shift     = eff - CODE_W'(1);

    // mask of period-1: bit g set when g lies below the period exponent
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign mask_o[g] = (int'(shift) > g);
    end

endmodule

// File: rtl/prg_tick_fsm.sv
module prg_tick_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic boundary_i,
    output logic tick_o
);
    import prg_pkg::*;

    prg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable_i && boundary_i) state_d = ST_FIRE;
                else if (enable_i)          state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!enable_i)       state_d = ST_IDLE;
                else if (boundary_i) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (!enable_i)       state_d = ST_IDLE;
                else if (boundary_i) state_d = ST_FIRE;
                else                 state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tick_o = (state_q == ST_FIRE);
    end

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
    parameter int CODE_W = prg_pkg::CODE_W,
    parameter int CNT_W  = prg_pkg::CNT_W,
    parameter int DIV_W  = prg_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_step_i,
    input  logic [CODE_W-1:0] rate_code_i,
    input  logic [DIV_W-1:0]  div_ctrl_i,
    input  logic              pie_en_i,
    output logic              pf_set_o,
    output logic              irq_req_o
);
    logic [CNT_W-1:0] cnt, cnt_next, mask;
    logic             adv, div_reset, code_nz, enable, boundary, tick;

    prg_prescaler #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_prescaler (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (ref_step_i),
        .div_ctrl_i  (div_ctrl_i),
        .cnt_o       (cnt),
        .cnt_next_o  (cnt_next),
        .adv_o       (adv),
        .div_reset_o (div_reset)
    );

    prg_rate_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_decode (
        .code_i    (rate_code_i),
        .code_nz_o (code_nz),
        .mask_o    (mask)
    );

    assign enable   = code_nz && pie_en_i;
    assign boundary = adv && ((cnt_next & mask) == '0);

    prg_tick_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .boundary_i (boundary),
        .tick_o     (tick)
    );

    assign pf_set_o  = tick;
    assign irq_req_o = tick;

    assert_code_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set_o |-> $past(rate_code_i != '0));

    assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> $past(pie_en_i));

    assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set_o |-> ((cnt & $past(mask)) == '0));

    assert_no_tick_div_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set_o |-> !$past(div_reset));

endmodule

// File: tb/periodic_rate_gen_bench.sv
`timescale 1ns/1ps
module periodic_rate_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_step = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic [2:0] div_ctrl = 3'b010;
    logic       pie_en = 1'b0;
    logic       pf_set, irq_req;

    int checks = 0;
    int fails  = 0;
    int ticks_seen = 0;
    bit done = 1'b0;

    logic [14:0] m_cnt = '0;
    logic        exp_tick = 1'b0;

    always #5 clk = ~clk;

    periodic_rate_gen u_periodic_rate_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_step_i  (ref_step),
        .rate_code_i (rate_code),
        .div_ctrl_i  (div_ctrl),
        .pie_en_i    (pie_en),
        .pf_set_o    (pf_set),
        .irq_req_o   (irq_req)
    );

    function automatic int period_of(input logic [3:0] c);
        int e;
        e = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
        return 1 << (e - 1);
    endfunction

    // model of one clock edge; returns whether a tick follows
    function automatic logic model_edge(input logic stp);
        logic hit;
        hit = 1'b0;
        if (div_ctrl[2:1] == 2'b11) begin
            m_cnt = '0;
        end else if (stp && div_ctrl <= 3'b010) begin
            m_cnt = m_cnt + 15'd1;
            if (rate_code != 4'd0 && pie_en)
                hit = ((int'(m_cnt) % period_of(rate_code)) == 0);
        end
        return hit;
    endfunction

    task automatic check_out(input string tag);
        checks++;
        if (pf_set !== exp_tick || irq_req !== exp_tick) begin
            fails++;
            $display("FAIL %s: pf=%b irq=%b expected %b", tag, pf_set, irq_req, exp_tick);
        end
        if (pf_set === 1'b1) ticks_seen++;
    endtask

    task automatic check_count(input string tag, input int exp);
        checks++;
        if (ticks_seen != exp) begin
            fails++;
            $display("FAIL %s: tick count %0d expected %0d", tag, ticks_seen, exp);
        end
    endtask

    task automatic run(input int nsteps, input int gap, input string tag);
        for (int s = 0; s < nsteps; s++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check_out(tag);
                ref_step = (g == gap - 1);
                exp_tick = model_edge(ref_step);
            end
        end
        @(negedge clk);
        check_out(tag);
        ref_step = 1'b0;
        exp_tick = model_edge(1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_step = 1'b0;
        m_cnt = '0;
        exp_tick = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (pf_set !== 1'b0 || irq_req !== 1'b0) begin
            fails++;
            $display("FAIL R1: outputs %b/%b in reset expected 0/0", pf_set, irq_req);
        end
        rst_n = 1'b1;
        ticks_seen = 0;
    endtask

    task automatic t_reset_R1();
        div_ctrl = 3'b010; pie_en = 1'b1; rate_code = 4'd3;
        do_reset();
        run(3, 1, "R1");
        check_count("R1", 0);
        run(1, 1, "R1");
        check_count("R1", 1);
    endtask

    task automatic t_period_R2();
        rate_code = 4'd3; do_reset();
        run(40, 1, "R2");
        check_count("R2", 10);
        rate_code = 4'd15; do_reset();
        run(16383, 1, "R2");
        check_count("R2", 0);
        run(1, 1, "R2");
        check_count("R2", 1);
    endtask

    task automatic t_alias_R3();
        rate_code = 4'd1; do_reset();
        run(256, 1, "R3");
        check_count("R3", 2);
        rate_code = 4'd8; do_reset();
        run(256, 1, "R3");
        check_count("R3", 2);
        rate_code = 4'd2; do_reset();
        run(255, 1, "R3");
        check_count("R3", 0);
        run(257, 1, "R3");
        check_count("R3", 2);
    endtask

    task automatic t_disable_R4_R5();
        rate_code = 4'd0; pie_en = 1'b1; do_reset();
        run(200, 1, "R4");
        check_count("R4", 0);
        rate_code = 4'd3; pie_en = 1'b0; do_reset();
        run(100, 1, "R5");
        check_count("R5", 0);
        pie_en = 1'b1;
    endtask

    task automatic t_align_R6();
        rate_code = 4'd0; do_reset();
        run(6, 1, "R6");
        rate_code = 4'd3;
        run(1, 1, "R6");
        check_count("R6", 0);
        run(1, 1, "R6");
        check_count("R6", 1);
    endtask

    task automatic t_div_reset_R7();
        rate_code = 4'd3; div_ctrl = 3'b110; do_reset();
        run(21, 1, "R7");
        check_count("R7", 0);
        div_ctrl = 3'b111;
        run(5, 1, "R7");
        check_count("R7", 0);
        div_ctrl = 3'b010;
        run(3, 1, "R7");
        check_count("R7", 0);
        run(1, 1, "R7");
        check_count("R7", 1);
    endtask

    task automatic t_div_freeze_R8();
        rate_code = 4'd3; div_ctrl = 3'b010; do_reset();
        run(2, 1, "R8");
        div_ctrl = 3'b011;
        run(20, 1, "R8");
        div_ctrl = 3'b101;
        run(7, 1, "R8");
        check_count("R8", 0);
        div_ctrl = 3'b000;
        run(1, 1, "R8");
        check_count("R8", 0);
        run(1, 1, "R8");
        check_count("R8", 1);
        div_ctrl = 3'b010;
    endtask

    task automatic t_rate_change_R9();
        rate_code = 4'd3; do_reset();
        run(6, 1, "R9");
        check_count("R9", 1);
        rate_code = 4'd5;
        run(9, 1, "R9");
        check_count("R9", 1);
        run(1, 1, "R9");
        check_count("R9", 2);
    endtask

    task automatic t_pulse_R10();
        rate_code = 4'd3; do_reset();
        run(12, 3, "R10");
        check_count("R10", 3);
    endtask

    initial begin
        t_reset_R1();
        t_period_R2();
        t_alias_R3();
        t_disable_R4_R5();
        t_align_R6();
        t_div_reset_R7();
        t_div_freeze_R8();
        t_rate_change_R9();
        t_pulse_R10();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule